// File: doc/BRIEF.md
# SPI Serial ROM Read Controller

This block is the host side of a link to a read-only serial memory on a four-wire SPI bus. A client hands it one request at a time: a 23-bit start address, a byte count and an access kind (normal read, high-speed read with one padding byte, or device identification). The controller drops chip select and runs a divided serial clock that idles low. It shifts out the opcode and any address and padding bits, then gathers the returned bytes MSB first. Each byte goes out on a valid/ready stream.

The serial clock rate is set per access kind by a half-period parameter counted in system clocks. The normal read and identification kinds share the slower setting. If the stream consumer stops taking bytes, the controller holds the serial clock low just before the rising edge that would finish the next byte. No byte is dropped and no buffer is needed. After each transaction chip select stays high for a programmable number of system clocks, and the busy flag covers that gap.

Top module: `spi_rom_reader`

## Requirements
- R1: A normal read (mode code 0) sends opcode 03h and then a 24-bit address field MSB first, 32 header bits in total. The field's top bit is 0 and its low 23 bits carry the request address. Data is captured starting with the next rising edge.
- R2: A high-speed read (mode code 1) sends opcode 0Bh, the same 24-bit address field and 8 padding bits. Data capture starts after those 40 header bits.
- R3: Identification (mode code 2) sends opcode 9Fh only and returns exactly three bytes, whatever the requested count.
- R4: Outgoing bits change only on the edge where the serial clock falls, never while it is high. Incoming bits are sampled on the edge where it rises. The serial clock is low whenever chip select is high.
- R5: Each serial clock phase lasts at least HALF_RD system clocks in modes 0 and 2, and at least HALF_FR system clocks in mode 1.
- R6: A request is taken only while busy is low. Busy rises with chip select and stays high until chip select has been high for GAP_CYC clocks, and chip select stays high at least GAP_CYC clocks between transactions.
- R7: A read delivers exactly the requested number of bytes in ascending address order, wrapping within 23 bits. Chip select rises after the last byte with no extra clock edges.
- R8: out_data stays stable while out_valid is high and out_ready is low. The serial clock stalls instead of losing a byte.
- R9: A request with count 0 in mode 0 or 1, or with mode code 3, is ignored. Chip select stays high and busy stays low.
- R10: After reset, chip select is high, the serial clock is low, and busy and out_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_mode | input | 2 | 0 normal read, 1 high-speed read, 2 identification, 3 ignored |
| req_addr | input | ADDR_W | Start address |
| req_len | input | LEN_W | Number of bytes to read (modes 0 and 1) |
| busy | output | 1 | Transaction or chip-select gap in progress |
| sck | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the memory |
| miso | input | 1 | Serial data from the memory |
| out_data | output | 8 | Received byte |
| out_valid | output | 1 | out_data holds an untaken byte |
| out_ready | input | 1 | Consumer takes the byte |

## Verification
Two events can land on the same system clock edge: the consumer taking a held byte, and the rising serial edge that completes the next byte. The stall logic has to let that edge through while also replacing out_data. The bench drives out_ready from a random pattern and from long low stretches, so the release often lines up exactly with the pending byte edge. It then compares every delivered byte, and the total count of serial edges seen by its memory model, against the values it expects.

// File: rtl/spi_rom_pkg.sv
package spi_rom_pkg;

  typedef enum logic [1:0] {
    MODE_READ  = 2'd0,
    MODE_FAST  = 2'd1,
    MODE_IDENT = 2'd2,
    MODE_NONE  = 2'd3
  } rom_mode_e;

  localparam int HDR_MAX  = 40;
  localparam int ID_BYTES = 3;

  function automatic logic [7:0] mode_opcode(rom_mode_e m);
    case (m)
      MODE_READ:  return 8'h03;
      MODE_FAST:  return 8'h0B;
      MODE_IDENT: return 8'h9F;
      default:    return 8'h00;
    endcase
  endfunction

  function automatic logic [5:0] mode_hdr_bits(rom_mode_e m);
    case (m)
      MODE_READ:  return 6'd32;
      MODE_FAST:  return 6'd40;
      MODE_IDENT: return 6'd8;
      default:    return 6'd0;
    endcase
  endfunction

  function automatic logic mode_legal(rom_mode_e m, logic len_zero);
    return (m == MODE_IDENT) || ((m != MODE_NONE) && !len_zero);
  endfunction

endpackage

// File: rtl/spi_rom_sckgen.sv
module spi_rom_sckgen #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] half,
  input  logic          hold,
  output logic          sck,
  output logic          rise_now,
  output logic          fall_now
);

  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end   = (cnt == half - 1'b1);
  assign rise_now = run && !sck && at_end && !hold;
  assign fall_now = run && sck && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (rise_now || fall_now) begin
      cnt <= '0;
      sck <= ~sck;
    end else if (!at_end) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/spi_rom_gap.sv
module spi_rom_gap #(
  parameter int GAP_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_release,
  output logic gap_busy
);

  localparam int GW = $clog2(GAP_CYC + 1);

  logic [GW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (cs_release) cnt <= GW'(GAP_CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign gap_busy = (cnt != '0);

endmodule

// File: rtl/spi_rom_reader.sv
module spi_rom_reader
  import spi_rom_pkg::*;
#(
  parameter int ADDR_W  = 23,
  parameter int LEN_W   = 8,
  parameter int HALF_RD = 3,
  parameter int HALF_FR = 2,
  parameter int GAP_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_mode,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              busy,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso,
  output logic [7:0]        out_data,
  output logic              out_valid,
  input  logic              out_ready
);

  localparam int HALF_MAX = (HALF_RD > HALF_FR) ? HALF_RD : HALF_FR;
  localparam int CW       = $clog2(HALF_MAX + 1);

  rom_mode_e            req_m;
  rom_mode_e            mode_q;
  logic                 act;
  logic [HDR_MAX-1:0]   hdr_sr;
  logic [5:0]           hdr_left;
  logic [2:0]           bit_idx;
  logic [LEN_W-1:0]     bytes_left;
  logic [6:0]           rx_sr;
  logic                 done;
  logic                 gap_busy;
  logic [CW-1:0]        half_sel;

  // named events
  logic accept, data_phase, byte_edge, hold, rise_now, fall_now, byte_done, txn_end;

  function automatic logic [HDR_MAX-1:0] header_word(rom_mode_e m, logic [ADDR_W-1:0] a);
    logic [HDR_MAX-1:0] w;
    w = '0;
    w[HDR_MAX-1 -: 8] = mode_opcode(m);
    w[8 +: ADDR_W]    = a;
    return w;
  endfunction

  assign req_m      = rom_mode_e'(req_mode);
  assign busy       = act || gap_busy;
  assign cs_n       = ~act;
  assign mosi       = hdr_sr[HDR_MAX-1];
  assign accept     = req_valid && !busy && mode_legal(req_m, req_len == '0);
  assign data_phase = (hdr_left == '0);
  assign byte_edge  = data_phase && (bit_idx == 3'd7);
  assign hold       = byte_edge && out_valid && !out_ready;
  assign byte_done  = rise_now && byte_edge;
  assign txn_end    = fall_now && done;
  assign half_sel   = (mode_q == MODE_FAST) ? CW'(HALF_FR) : CW'(HALF_RD);

  spi_rom_sckgen #(.CW(CW)) u_sckgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (act),
    .half     (half_sel),
    .hold     (hold),
    .sck      (sck),
    .rise_now (rise_now),
    .fall_now (fall_now)
  );

  spi_rom_gap #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_release (txn_end),
    .gap_busy   (gap_busy)
  );

  // sequencer: header, data capture, end of transaction
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act        <= 1'b0;
      mode_q     <= MODE_READ;
      hdr_sr     <= '0;
      hdr_left   <= '0;
      bit_idx    <= '0;
      bytes_left <= '0;
      rx_sr      <= '0;
      done       <= 1'b0;
    end else if (accept) begin
      act        <= 1'b1;
      mode_q     <= req_m;
      hdr_sr     <= header_word(req_m, req_addr);
      hdr_left   <= mode_hdr_bits(req_m);
      bit_idx    <= '0;
      bytes_left <= (req_m == MODE_IDENT) ? LEN_W'(ID_BYTES) : req_len;
      done       <= 1'b0;
    end else begin
      if (rise_now) begin
        if (!data_phase) begin
          hdr_left <= hdr_left - 1'b1;
        end else begin
          rx_sr   <= {rx_sr[5:0], miso};
          bit_idx <= bit_idx + 1'b1;
          if (byte_edge) begin
            bytes_left <= bytes_left - 1'b1;
            if (bytes_left == LEN_W'(1)) done <= 1'b1;
          end
        end
      end
      if (fall_now) hdr_sr <= {hdr_sr[HDR_MAX-2:0], 1'b0};
      if (txn_end) begin
        act  <= 1'b0;
        done <= 1'b0;
      end
    end
  end

  // output stream register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (byte_done) begin
      out_valid <= 1'b1;
      out_data  <= {rx_sr, miso};
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_rom_reader_chk.sv
module spi_rom_reader_chk #(
  parameter int LEN_W   = 8,
  parameter int HALF_FR = 2,
  parameter int GAP_CYC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       req_mode,
  input logic [LEN_W-1:0] req_len,
  input logic             busy,
  input logic             sck,
  input logic             cs_n,
  input logic             mosi,
  input logic [7:0]       out_data,
  input logic             out_valid,
  input logic             out_ready
);

  logic [15:0] sck_run;
  logic [15:0] hi_run;
  logic        p_sck;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_run <= 16'hFFFF;
      hi_run  <= 16'hFFFF;
      p_sck   <= 1'b0;
    end else begin
      p_sck   <= sck;
      sck_run <= (sck != p_sck) ? 16'd1 : ((sck_run == 16'hFFFF) ? sck_run : sck_run + 1'b1);
      hi_run  <= !cs_n ? 16'd0 : ((hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1);
    end
  end

  p_idle_sck_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  p_mosi_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
  p_mosi_at_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(mosi));
  p_half_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sck != p_sck) |-> (sck_run >= 16'(HALF_FR)));
  p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (hi_run >= 16'(GAP_CYC)));
  p_busy_cover_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);
  p_accept_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !$past(busy));
  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && (req_mode == 2'd3 || (req_mode != 2'd2 && req_len == '0))) |=> cs_n);

endmodule

bind spi_rom_reader spi_rom_reader_chk #(
  .LEN_W(LEN_W), .HALF_FR(HALF_FR), .GAP_CYC(GAP_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
  .req_len(req_len), .busy(busy), .sck(sck), .cs_n(cs_n), .mosi(mosi),
  .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
);

// File: tb/test_spi_rom_reader.sv
module test_spi_rom_reader;

  localparam int ADDR_W = 23, LEN_W = 8, HALF_RD = 3, HALF_FR = 2, GAP_CYC = 8;

  logic clk, rst_n, req_valid, busy, sck, cs_n, mosi, miso, out_valid, out_ready;
  logic [1:0] req_mode;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W-1:0] req_len;
  logic [7:0] out_data;

  spi_rom_reader #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .HALF_RD(HALF_RD),
                   .HALF_FR(HALF_FR), .GAP_CYC(GAP_CYC)) i_spi_rom_reader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_addr(req_addr), .req_len(req_len), .busy(busy), .sck(sck), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_tests = 0, n_fail = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rom_byte(logic [22:0] a);
    return a[7:0] ^ a[15:8] ^ {1'b0, a[22:16]} ^ 8'hC3;
  endfunction

  function automatic logic [7:0] id_byte(int i);
    case (i)
      0: return 8'hAE;
      1: return 8'h41;
      2: return 8'h15;
      default: return 8'h00;
    endcase
  endfunction

  // serial memory model
  int m_bits = 0, m_hb = 99, m_txn = 0;
  logic [39:0] m_hdr = '0;
  logic [7:0] m_cmd = '0;

  function automatic logic [7:0] model_byte(int i);
    logic [22:0] a;
    if (m_cmd == 8'h9F) return id_byte(i);
    a = (m_cmd == 8'h0B) ? m_hdr[30:8] : m_hdr[22:0];
    return rom_byte(a + 23'(i));
  endfunction

  initial miso = 1'b0;

  always @(negedge cs_n) begin
    m_bits = 0; m_hb = 99; m_hdr = '0; m_cmd = '0; miso = 1'b0;
    m_txn++;
  end

  always @(posedge sck) if (!cs_n) begin
    if (m_bits < m_hb) m_hdr = {m_hdr[38:0], mosi};
    m_bits++;
    if (m_bits == 8) begin
      m_cmd = m_hdr[7:0];
      m_hb = (m_cmd == 8'h03) ? 32 : (m_cmd == 8'h0B) ? 40 : (m_cmd == 8'h9F) ? 8 : 99;
    end
  end

  always @(negedge sck) if (!cs_n && m_bits >= m_hb) begin
    int idx;
    logic [7:0] b;
    idx = m_bits - m_hb;
    b = model_byte(idx / 8);
    miso = b[7 - (idx % 8)];
  end

  // consumer and line monitors
  int stall_cnt = 0, rx_n = 0;
  logic [7:0] rx [0:63];
  bit bad_line = 0;
  int min_half = 1000, hrun = 1000, crun = 1000;
  logic p_sck = 1'b0, p_mosi = 1'b0, p_cs = 1'b1;

  initial out_ready = 1'b0;

  always @(negedge clk) begin
    if (stall_cnt > 0) begin
      stall_cnt--;
      out_ready = 1'b0;
    end else begin
      out_ready = ($urandom % 4) != 0;
    end
    if (out_valid && out_ready && rx_n < 64) begin
      rx[rx_n] = out_data;
      rx_n++;
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (cs_n && sck) bad_line = 1;
    if (!cs_n && sck && p_sck && mosi != p_mosi) bad_line = 1;
    if (sck != p_sck) begin
      if (!p_cs && hrun < min_half) min_half = hrun;
      hrun = 1;
    end else begin
      hrun++;
    end
    if (!cs_n && p_cs) check(crun >= GAP_CYC, "R6 chip-select high gap", crun, GAP_CYC);
    crun = cs_n ? crun + 1 : 0;
    p_sck = sck; p_mosi = mosi; p_cs = cs_n;
  end

  task automatic run_txn(input logic [1:0] md, input logic [22:0] ad, input logic [7:0] ln,
                         input bit poke, input int stall);
    int t0, nexp, hb;
    bit legal;
    string tg;
    legal = (md == 2'd2) || (md != 2'd3 && ln != 0);
    nexp  = (md == 2'd2) ? 3 : int'(ln);
    hb    = (md == 2'd0) ? 32 : (md == 2'd1) ? 40 : 8;
    tg    = (stall > 0) ? "R8" : (md == 2'd0) ? "R1" : (md == 2'd1) ? "R2" : "R3";
    t0 = m_txn; rx_n = 0; bad_line = 0; min_half = 1000;
    stall_cnt = stall;
    @(negedge clk);
    req_mode = md; req_addr = ad; req_len = ln; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (legal) check(busy == 1'b1, "R6 busy after accepted request", busy, 1);
    else       check(busy == 1'b0 && cs_n == 1'b1, "R9 ignored request leaves busy low", busy, 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      req_mode = 2'd0; req_addr = 23'h1; req_len = 8'd1; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (busy || out_valid) @(negedge clk);
    repeat (20) @(negedge clk);
    if (!legal) begin
      check(m_txn == t0, "R9 no transaction issued", m_txn - t0, 0);
      check(rx_n == 0, "R9 no bytes delivered", rx_n, 0);
    end else begin
      check(m_txn == t0 + 1, "R6 exactly one transaction", m_txn - t0, 1);
      check(m_cmd == ((md == 2'd0) ? 8'h03 : (md == 2'd1) ? 8'h0B : 8'h9F),
            {tg, " opcode"}, m_cmd, md);
      if (md != 2'd2) begin
        logic [23:0] fld;
        fld = (md == 2'd0) ? m_hdr[23:0] : m_hdr[31:8];
        check(fld == {1'b0, ad}, {tg, " address field"}, fld, {1'b0, ad});
      end
      check(rx_n == nexp, "R7 byte count", rx_n, nexp);
      check(m_bits == hb + 8 * nexp, "R7 serial edge count", m_bits, hb + 8 * nexp);
      for (int i = 0; i < nexp && i < rx_n; i++) begin
        logic [7:0] e;
        e = (md == 2'd2) ? id_byte(i) : rom_byte(ad + 23'(i));
        check(rx[i] == e, {tg, " data byte"}, rx[i], e);
      end
      check(!bad_line, "R4 data line stable while clock high, clock low when idle", bad_line, 0);
      check(min_half >= ((md == 2'd1) ? HALF_FR : HALF_RD), "R5 clock half period",
            min_half, (md == 2'd1) ? HALF_FR : HALF_RD);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; req_valid = 1'b0; req_mode = '0; req_addr = '0; req_len = '0;
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1 && sck == 1'b0 && busy == 1'b0 && out_valid == 1'b0,
          "R10 reset state", {cs_n, sck, busy, out_valid}, 4'b1000);
    rst_n = 1'b1;
    run_txn(2'd0, 23'h000000, 8'd1, 0, 0);
    run_txn(2'd1, 23'h7FFFFE, 8'd4, 0, 0);
    run_txn(2'd2, 23'h123456, 8'd0, 0, 0);
    run_txn(2'd2, 23'h000000, 8'd7, 0, 0);
    run_txn(2'd0, 23'h0ABCDE, 8'd0, 0, 0);
    run_txn(2'd1, 23'h000010, 8'd0, 0, 0);
    run_txn(2'd3, 23'h000010, 8'd5, 0, 0);
    run_txn(2'd0, 23'h2AAAAA, 8'd3, 1, 0);
    run_txn(2'd1, 23'h555555, 8'd4, 0, 300);
    run_txn(2'd0, 23'h400000, 8'd3, 0, 150);
    for (int k = 0; k < 24; k++) begin
      logic [1:0] md;
      logic [22:0] ad;
      logic [7:0] ln;
      md = 2'($urandom % 4);
      ad = 23'($urandom);
      ln = 8'($urandom % 7);
      run_txn(md, ad, ln, 0, (k % 5 == 0) ? 40 : 0);
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule